// File: doc/BRIEF.md
# Three-Channel Reload Down-Counter Timer

This block is a bus-programmed timer unit with three independent 32-bit channels. All channels share one free-running prescaler and one run-control register. Each channel holds a reload value, a live count and a control word. A running channel decrements its count once per tick of its chosen prescaled rate. A tick that finds the count at zero makes the channel reload, latch a sticky underflow flag and, when enabled, assert its interrupt line.

Software reads and writes the registers through a plain synchronous bus. Each write commits on the rising clock edge and the read data is combinational from the address. Data is right-aligned on the 32-bit data bus, and each register takes as many low bits as it is wide. Typical uses are a periodic tick source (non-zero reload) or a single delay (reload of zero with the interrupt disabled after the first event).

Top module: `tmr_top`

## Requirements
- R1: A running channel's count drops by one on every tick of its prescaled rate. A tick that finds the count at zero loads the count from the channel's reload register instead.
- R2: The run register at byte address 0x02 has one bit per channel (bit n for channel n, bits 2:0). When bit n is clear, channel n's count holds its value. Bits above bit 2 are ignored and read as 0.
- R3: Bit 8 of a channel's control word is the underflow flag. An underflow sets it, and it stays set until a control write with bit 8 at 0. A write with bit 8 at 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves it set.
- R4: Bit 5 of the control word is the interrupt enable. Interrupt line n is high whenever channel n's flag and enable are both 1.
- R5: Bits 2:0 of the control word select the rate. Selection s in 0..3 gives one tick every 4<<(2s) clocks (4, 16, 64, 256). Selections 4..7 behave as 256. Underflows repeat every (reload+1) times that divisor. The selection reads back as written. All control bits other than 8, 5 and 2:0 read 0.
- R6: Channel n's registers lie at byte address 0x04+12n: reload at +0, count at +4, control at +8. Reads from any unmapped address return 0.
- R7: A count write takes priority over a decrement or reload in the same cycle, and that cycle raises no underflow.
- R8: With a reload value of 0, the channel underflows on every tick and its count stays at 0.
- R9: After reset, the run bits, flags, enables and selections are 0, the counts and reload values are all ones, and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, committed on the rising edge |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data for bus_addr, right-aligned |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The main check measures the spacing between successive interrupt edges. It covers every channel, every legal rate selection, one reserved selection and reload values including zero. Because each pair differs in reload or divisor, a wrong divisor, an off-by-one reload or a miswired channel produces a visibly different period. Directed sequences then exercise a fixed-length decrement window, freezing by the run bits, the write-one/write-zero flag semantics, the register map and readback masks, and count writes held over the ticks that would otherwise underflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W    = 32;
  localparam int CTL_W    = 16;
  localparam int NUM_SEL  = 4;
  localparam int FLAG_BIT = 8;
  localparam int IE_BIT   = 5;
  localparam int SEL_W    = 3;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SEL_W-1:0] sel_t;

  // Reserved selections fold onto the slowest rate.
  function automatic logic [1:0] eff_sel(input sel_t s);
    return (s > sel_t'(NUM_SEL-1)) ? 2'(NUM_SEL-1) : s[1:0];
  endfunction

  // Value the count takes on a tick.
  function automatic cnt_t tick_value(input cnt_t cur, input cnt_t rld);
    return (cur == '0) ? rld : cur - cnt_t'(1);
  endfunction

  // Byte address of a channel register.
  function automatic int reg_addr(input int ch, input int off);
    return 4 + 12 * ch + off;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int NSEL = NUM_SEL
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSEL-1:0] tick
);
  localparam int PRE_W = 2 * NSEL;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(1);
  end

  // Rate s ticks when the low 2(s+1) bits are all ones.
  for (genvar s = 0; s < NSEL; s++) begin : g_tick
    assign tick[s] = &pre_q[2*s+1:0];
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int NSEL = NUM_SEL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [NSEL-1:0]  tick,
  input  logic             wr_rld,
  input  logic             wr_cnt,
  input  logic             wr_ctl,
  input  logic [CNT_W-1:0] wdata,
  output cnt_t             cnt,
  output cnt_t             rld,
  output logic [CTL_W-1:0] ctl_rd,
  output logic             flag,
  output logic             ie,
  output logic             step,
  output logic             uf_evt,
  output logic             irq
);
  sel_t sel_q;
  logic flag_q, ie_q;
  cnt_t cnt_q, rld_q;

  assign step   = run & tick[eff_sel(sel_q)];
  assign uf_evt = step & (cnt_q == '0) & ~wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      rld_q <= '1;
    end else begin
      if (wr_rld) rld_q <= wdata;
      if (wr_cnt)    cnt_q <= wdata;
      else if (step) cnt_q <= tick_value(cnt_q, rld_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        sel_q <= wdata[SEL_W-1:0];
        ie_q  <= wdata[IE_BIT];
      end
      if (uf_evt)                          flag_q <= 1'b1;
      else if (wr_ctl && !wdata[FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_rd               = '0;
    ctl_rd[SEL_W-1:0]    = sel_q;
    ctl_rd[IE_BIT]       = ie_q;
    ctl_rd[FLAG_BIT]     = flag_q;
  end

  assign cnt  = cnt_q;
  assign rld  = rld_q;
  assign flag = flag_q;
  assign ie   = ie_q;
  assign irq  = flag_q & ie_q;
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 6,
  parameter int RUN_AD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    irq
);
  logic [NUM_SEL-1:0]        tick;
  logic [NCH-1:0]            run_q;
  logic [NCH-1:0]            wr_rld, wr_cnt, wr_ctl;
  logic [NCH-1:0]            flag_vec, ie_vec, step, uf_evt;
  logic [NCH-1:0][CNT_W-1:0] cnt_vec, rld_vec;
  logic [NCH-1:0][CTL_W-1:0] ctl_vec;

  tmr_prescaler #(.NSEL(NUM_SEL)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      run_q <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(RUN_AD))  run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int A_RLD = reg_addr(i, 0);
    localparam int A_CNT = reg_addr(i, 4);
    localparam int A_CTL = reg_addr(i, 8);

    assign wr_rld[i] = bus_wr && bus_addr == ADDR_W'(A_RLD);
    assign wr_cnt[i] = bus_wr && bus_addr == ADDR_W'(A_CNT);
    assign wr_ctl[i] = bus_wr && bus_addr == ADDR_W'(A_CTL);

    tmr_channel #(.NSEL(NUM_SEL)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run_q[i]), .tick(tick),
      .wr_rld(wr_rld[i]), .wr_cnt(wr_cnt[i]), .wr_ctl(wr_ctl[i]),
      .wdata(bus_wdata), .cnt(cnt_vec[i]), .rld(rld_vec[i]),
      .ctl_rd(ctl_vec[i]), .flag(flag_vec[i]), .ie(ie_vec[i]),
      .step(step[i]), .uf_evt(uf_evt[i]), .irq(irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(RUN_AD)) bus_rdata = CNT_W'(run_q);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(reg_addr(i, 0))) bus_rdata = rld_vec[i];
      if (bus_addr == ADDR_W'(reg_addr(i, 4))) bus_rdata = cnt_vec[i];
      if (bus_addr == ADDR_W'(reg_addr(i, 8))) bus_rdata = CNT_W'(ctl_vec[i]);
    end
  end
endmodule

// File: rtl/tmr_checks.sv
module tmr_checks
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            run,
  input logic [NCH-1:0]            wr_cnt,
  input logic [NCH-1:0]            wr_ctl,
  input logic [NCH-1:0]            step,
  input logic [NCH-1:0]            uf_evt,
  input logic [NCH-1:0]            flag,
  input logic [NCH-1:0]            ie,
  input logic [NCH-1:0]            irq,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0][CNT_W-1:0] rld,
  input logic [CNT_W-1:0]          wdata
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      step[i] && !wr_cnt[i] && cnt[i] != '0 |=> cnt[i] == $past(cnt[i]) - 1); // R1
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt[i] |=> cnt[i] == $past(rld[i])); // R1
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] && !wr_cnt[i] |=> $stable(cnt[i])); // R2
    AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt[i] |=> flag[i]); // R3
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt[i] && ie[i] && !wr_ctl[i] |=> irq[i]); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt[i] |=> cnt[i] == $past(wdata)); // R7
  end
endmodule

bind tmr_top tmr_checks #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl),
  .step(step), .uf_evt(uf_evt), .flag(flag_vec), .ie(ie_vec), .irq(irq),
  .cnt(cnt_vec), .rld(rld_vec), .wdata(bus_wdata)
);

// File: tb/tmr_top_tb.sv
module tmr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  tmr_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam int NV = 6;
  localparam int V_CH  [NV] = '{0, 1, 2, 0, 1, 2};
  localparam int V_SEL [NV] = '{0, 1, 2, 3, 5, 0};
  localparam int V_RLD [NV] = '{0, 2, 1, 1, 0, 9};

  function automatic int a_rld(int ch); return 4 + 12*ch;     endfunction
  function automatic int a_cnt(int ch); return 4 + 12*ch + 4; endfunction
  function automatic int a_ctl(int ch); return 4 + 12*ch + 8; endfunction

  function automatic int period(int sel, int rv);
    int s;
    s = (sel > 3) ? 3 : sel;
    return (rv + 1) * (4 << (2 * s));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(int a, logic [31:0] d);
    bus_addr = 6'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = 6'(a);
    #1 d = bus_rdata;
  endtask

  task automatic wait_irq(int ch, output int n);
    n = 0;
    while (irq[ch] !== 1'b1 && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    rd(a_cnt(0), d); check("R9 count", d, 32'hFFFF_FFFF);
    rd(a_rld(2), d); check("R9 reload", d, 32'hFFFF_FFFF);
    rd(a_ctl(1), d); check("R9 control", d, 32'h0);
    rd(2, d);        check("R9 run", d, 32'h0);
    check("R9 irq", 32'(irq), 32'h0);

    // R5, R8: period table
    for (int v = 0; v < NV; v++) begin
      int ch;
      ch = V_CH[v];
      wr(a_rld(ch), 32'(V_RLD[v]));
      wr(a_cnt(ch), 32'(V_RLD[v]));
      wr(a_ctl(ch), 32'h20 | 32'(V_SEL[v]));
      wr(2, 32'(1 << ch));
      wait_irq(ch, n);
      wr(a_ctl(ch), 32'h20 | 32'(V_SEL[v]));
      n = 1;
      while (irq[ch] !== 1'b1 && n < 5000) begin
        @(negedge clk); n++;
      end
      check($sformatf("R5 R8 period vec%0d", v), 32'(n), 32'(period(V_SEL[v], V_RLD[v])));
      wr(2, 0);
      wr(a_ctl(ch), 32'h0);
    end

    // R8: reload of zero keeps count at zero
    rd(a_cnt(1), d); check("R8 count stays 0", d, 32'h0);

    // R1: ten ticks in forty cycles at divide-by-4
    wr(a_cnt(0), 1000);
    wr(a_ctl(0), 0);
    wr(2, 1);
    repeat (40) @(negedge clk);
    rd(a_cnt(0), d); check("R1 decrement", d, 990);

    // R2: freeze when run bit is cleared
    wr(2, 0);
    rd(a_cnt(0), d);
    repeat (20) @(negedge clk);
    rd(a_cnt(0), d2); check("R2 frozen", d2, d);
    wr(2, 32'hFF);
    rd(2, d); check("R2 run readback", d, 32'h7);
    wr(2, 0);

    // R3, R4: sticky flag, write semantics, enable off
    wr(a_rld(1), 0); wr(a_cnt(1), 0);
    wr(a_ctl(1), 32'h0);
    wr(2, 2);
    repeat (10) @(negedge clk);
    wr(2, 0);
    rd(a_ctl(1), d); check("R3 flag set", d, 32'h100);
    check("R4 irq masked", 32'(irq[1]), 0);
    wr(a_ctl(1), 32'h120);
    rd(a_ctl(1), d); check("R3 write1 keeps", d, 32'h120);
    check("R4 irq on", 32'(irq[1]), 1);
    wr(a_ctl(1), 32'h020);
    rd(a_ctl(1), d); check("R3 write0 clears", d, 32'h020);
    check("R4 irq off", 32'(irq[1]), 0);

    // R5, R6: readback masks and map
    wr(a_ctl(2), 32'hFFFF);
    rd(a_ctl(2), d); check("R5 control mask", d, 32'h027);
    wr(a_ctl(2), 0);
    wr(16, 32'hA5A5_0001);
    rd(a_rld(1), d); check("R6 ch1 reload addr", d, 32'hA5A5_0001);
    wr(36, 32'h13);
    rd(a_ctl(2), d); check("R6 ch2 control addr", d, 32'h3);
    rd(40, d); check("R6 unmapped", d, 32'h0);

    // R7: count writes hold over zero-count ticks
    wr(a_rld(0), 5); wr(a_cnt(0), 0);
    wr(a_ctl(0), 32'h20);
    wr(2, 1);
    for (int k = 0; k < 16; k++) wr(a_cnt(0), 0);
    wr(a_cnt(0), 1000);
    wr(2, 0);
    rd(a_ctl(0), d); check("R7 no underflow", d, 32'h20);
    rd(a_cnt(0), d); check("R7 count written", d, 1000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule